// File: doc/BRIEF.md
# Dual-Mode Down-Counting Timer

A memory-mapped down-counter with one interrupt line, attached to a simple 32-bit register bus (word address, write strobe, read strobe, write data, combinational read data). Software writes a reload value as two 32-bit words while the timer is stopped, then sets the run bit. From that moment the counter takes the reload value and decrements by one each clock. The count can span 32 bits, with only the low word in use, or 64 bits, with a borrow from the low word into the high word. The choice is a control bit that software may change at run time.

When the count is zero the timer expires. In one-shot mode it then stays at zero until it is stopped and started again. In periodic mode it reloads and keeps going, so a reload value N gives one expiry every N+1 clocks. Each expiry sets a sticky raw status flag. ANDing that flag with an interrupt enable gives the masked flag, which drives the interrupt output. Writing a one to the clear bit drops the flag.

The live count can be read directly. It can also be read through a snapshot pair: reading the low snapshot word returns the live low word and latches the high word at the same moment, so a later read of the high snapshot word belongs to the same count. Software that wants a rising count reads the bitwise inverse of the value.

Top module: `dwn_timer_top`

## Requirements
- R1: After a synchronous active-low reset every register reads zero and `irq_o` is low. The timer is stopped, in one-shot mode, 32 bits wide, with its interrupt disabled.
- R2: A write to the control word (word index 4, byte 0x10) that sets the run bit (bit 1) while the timer is stopped loads the counter on that clock edge. The low word comes from the low reload word (index 0). The high word comes from the high reload word (index 1) when that same write sets the width bit (bit 16), and is zero otherwise.
- R3: While running, the count (low word at index 2) drops by one per clock. Clearing the run bit freezes the count, and the frozen value stays readable.
- R4: With the periodic bit (control bit 0) set, a zero count expires and the counter reloads on the same edge, giving one expiry every N+1 clocks for a reload value N.
- R5: With the periodic bit clear, an expiry leaves the count at zero. There are no further expiries until the timer is stopped and started again.
- R6: In 64-bit mode a decrement of a zero low word borrows from the high word, and expiry occurs only when all 64 bits are zero.
- R7: In 32-bit mode only the low word counts, and the high count word (index 3) reads zero.
- R8: Each expiry sets raw status (interrupt word index 5, bit 1) whatever the enable bit (bit 0) holds. Masked status (bit 2) is raw status ANDed with the enable bit, and `irq_o` follows masked status.
- R9: Writing the interrupt word with bit 3 set clears raw status. If an expiry happens on the same edge, the expiry wins and the status stays set.
- R10: A read of the low snapshot word (index 6) returns the live low count and latches the high count (zero in 32-bit mode). The high snapshot word (index 7) returns that latched value until the next low snapshot read.
- R11: Both reload words read back in full. The control word reads back only bits 0, 1 and 16, and the interrupt word only bits 0 to 2, with bit 3 reading zero. Writes to count or snapshot words, and accesses whose address has nonzero bits [1:0], change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Byte address; bits [4:2] select the word |
| bus_we | input | 1 | Write strobe, one access per clock |
| bus_re | input | 1 | Read strobe; only needed for the snapshot latch |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for the addressed word |
| irq_o | output | 1 | Level interrupt, equal to masked status |

## Verification
The bound checker watches, on every clock, the following properties: the count decrements by one while running, the count holds while stopped, the counter loads on a start, a one-shot count stays at zero, raw status is sticky, and the high count word reads zero in 32-bit mode. Some behaviour can only be shown by the bench's scenarios, because it depends on a sequence of bus accesses:
- the N+1 periodic spacing;
- the borrow across the word boundary at a chosen point;
- the expiry winning over a clear that lands on the same edge;
- the agreement of the snapshot pair across two separate reads;
- read-only and misaligned accesses leaving the state untouched.

A clocked model in the bench, driven by fixed-seed random traffic, covers the mixed orderings.

// File: rtl/dwn_timer_pkg.sv
// Shared constants for the down-counting timer: word indices on the
// register bus and bit positions inside the control and interrupt words.
// Assumes a 32-bit data word and word-aligned byte addresses.
package dwn_timer_pkg;

    localparam int unsigned WORD_IDX_W = 3;

    typedef enum logic [WORD_IDX_W-1:0] {
        IDX_RELOAD_LO = 3'd0,
        IDX_RELOAD_HI = 3'd1,
        IDX_COUNT_LO  = 3'd2,
        IDX_COUNT_HI  = 3'd3,
        IDX_CTRL      = 3'd4,
        IDX_IRQ       = 3'd5,
        IDX_SNAP_LO   = 3'd6,
        IDX_SNAP_HI   = 3'd7
    } word_idx_e;

    localparam int unsigned CTRL_PERIODIC_BIT = 0;
    localparam int unsigned CTRL_RUN_BIT      = 1;
    localparam int unsigned CTRL_WIDE_BIT     = 16;

    localparam int unsigned IRQ_ENABLE_BIT = 0;
    localparam int unsigned IRQ_RAW_BIT    = 1;
    localparam int unsigned IRQ_MASKED_BIT = 2;
    localparam int unsigned IRQ_CLEAR_BIT  = 3;

endpackage

// File: rtl/dwn_timer_regs.sv
// Register file and bus decode for the timer.
// Holds the reload words, the control bits, the interrupt enable and the
// latched high snapshot word. Produces a start pulse on a 0->1 run
// transition and a clear pulse for the status flag. Read data is
// combinational from the address.
// Assumes one access per clock and DATA_W > CTRL_WIDE_BIT.
module dwn_timer_regs
    import dwn_timer_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              raw,
    input  logic              masked,
    output logic [DATA_W-1:0] reload_lo,
    output logic [DATA_W-1:0] reload_hi,
    output logic              periodic,
    output logic              run,
    output logic              wide,
    output logic              int_en,
    output logic              start,
    output logic              start_wide,
    output logic              clr
);

    logic                  upper_ok;
    logic                  in_range;
    logic [WORD_IDX_W-1:0] idx;
    logic                  wr;
    logic                  rd;
    logic [DATA_W-1:0]     snap_hi_q;
    logic [DATA_W-1:0]     cnt_hi_view;

    // Address bits above the 8-word window must be zero (only when present).
    generate
        if (ADDR_W > 5) begin : g_upper
            assign upper_ok = (bus_addr[ADDR_W-1:5] == '0);
        end else begin : g_noupper
            assign upper_ok = 1'b1;
        end
    endgenerate

    assign in_range = upper_ok && (bus_addr[1:0] == 2'b00);
    assign idx      = bus_addr[4:2];
    assign wr       = bus_we && in_range;
    assign rd       = bus_re && in_range;

    assign start      = wr && (idx == IDX_CTRL) && bus_wdata[CTRL_RUN_BIT] && !run;
    assign start_wide = bus_wdata[CTRL_WIDE_BIT];
    assign clr        = wr && (idx == IDX_IRQ) && bus_wdata[IRQ_CLEAR_BIT];

    assign cnt_hi_view = wide ? cnt[CNT_W-1:DATA_W] : '0;

    // Software-writable words: reload pair, control bits, interrupt enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_lo <= '0;
            reload_hi <= '0;
            periodic  <= 1'b0;
            run       <= 1'b0;
            wide      <= 1'b0;
            int_en    <= 1'b0;
        end else if (wr) begin
            case (idx)
                IDX_RELOAD_LO: reload_lo <= bus_wdata;
                IDX_RELOAD_HI: reload_hi <= bus_wdata;
                IDX_CTRL: begin
                    periodic <= bus_wdata[CTRL_PERIODIC_BIT];
                    run      <= bus_wdata[CTRL_RUN_BIT];
                    wide     <= bus_wdata[CTRL_WIDE_BIT];
                end
                IDX_IRQ:  int_en <= bus_wdata[IRQ_ENABLE_BIT];
                default: ;
            endcase
        end
    end

    // Latch the high count when software reads the low snapshot word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_hi_q <= '0;
        end else if (rd && (idx == IDX_SNAP_LO)) begin
            snap_hi_q <= cnt_hi_view;
        end
    end

    // Combinational read mux over the eight words.
    always_comb begin
        bus_rdata = '0;
        if (in_range) begin
            case (idx)
                IDX_RELOAD_LO: bus_rdata = reload_lo;
                IDX_RELOAD_HI: bus_rdata = reload_hi;
                IDX_COUNT_LO:  bus_rdata = cnt[DATA_W-1:0];
                IDX_COUNT_HI:  bus_rdata = cnt_hi_view;
                IDX_CTRL: begin
                    bus_rdata[CTRL_PERIODIC_BIT] = periodic;
                    bus_rdata[CTRL_RUN_BIT]      = run;
                    bus_rdata[CTRL_WIDE_BIT]     = wide;
                end
                IDX_IRQ: begin
                    bus_rdata[IRQ_ENABLE_BIT] = int_en;
                    bus_rdata[IRQ_RAW_BIT]    = raw;
                    bus_rdata[IRQ_MASKED_BIT] = masked;
                end
                IDX_SNAP_LO:   bus_rdata = cnt[DATA_W-1:0];
                IDX_SNAP_HI:   bus_rdata = snap_hi_q;
                default:       bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dwn_timer_count.sv
// The down-counter itself.
// Loads on a start pulse and decrements while running. In 32-bit mode only
// the low word moves and the zero test looks at the low word; in 64-bit
// mode the full width moves and the test looks at all of it. A zero count
// expires: it reloads when periodic, and otherwise parks at zero until the
// next start.
// Assumes start is only raised while the timer is stopped.
module dwn_timer_count #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_wide,
    input  logic              run,
    input  logic              periodic,
    input  logic              wide,
    input  logic [DATA_W-1:0] reload_lo,
    input  logic [DATA_W-1:0] reload_hi,
    output logic [CNT_W-1:0]  cnt,
    output logic              expire
);

    logic              done_q;
    logic              zero;
    logic [DATA_W-1:0] lo_dec;

    assign zero   = wide ? (cnt == '0) : (cnt[DATA_W-1:0] == '0);
    assign expire = run && !start && zero && (periodic || !done_q);
    assign lo_dec = cnt[DATA_W-1:0] - 1'b1;

    // Count register and the one-shot parked flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            done_q <= 1'b0;
        end else if (start) begin
            cnt    <= {(start_wide ? reload_hi : {DATA_W{1'b0}}), reload_lo};
            done_q <= 1'b0;
        end else if (run) begin
            if (expire) begin
                if (periodic) begin
                    cnt <= {(wide ? reload_hi : {DATA_W{1'b0}}), reload_lo};
                end else begin
                    done_q <= 1'b1;
                end
            end else if (!zero) begin
                if (wide) begin
                    cnt <= cnt - 1'b1;
                end else begin
                    cnt[DATA_W-1:0] <= lo_dec;
                end
            end
        end
    end

endmodule

// File: rtl/dwn_timer_irq.sv
// Interrupt status: a sticky raw flag set by expiry and cleared by a
// write-one-to-clear pulse (expiry has priority), plus the masked view.
// Assumes expire and clr are single-clock qualified pulses.
module dwn_timer_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr,
    input  logic int_en,
    output logic raw,
    output logic masked,
    output logic irq_o
);

    // Sticky raw status; set beats clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw <= 1'b0;
        end else if (expire) begin
            raw <= 1'b1;
        end else if (clr) begin
            raw <= 1'b0;
        end
    end

    assign masked = raw && int_en;
    assign irq_o  = masked;

endmodule

// File: rtl/dwn_timer_top.sv
// Top of the dual-width down-counting timer: wires the register file,
// the counter and the interrupt status together.
// Assumes a single clock domain and a synchronous active-low reset.
module dwn_timer_top #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);

    localparam int unsigned CNT_W = 2 * DATA_W;

    logic [DATA_W-1:0] reload_lo_w;
    logic [DATA_W-1:0] reload_hi_w;
    logic              periodic_w;
    logic              run_w;
    logic              wide_w;
    logic              int_en_w;
    logic              start_w;
    logic              start_wide_w;
    logic              clr_w;
    logic [CNT_W-1:0]  cnt_w;
    logic              expire_w;
    logic              raw_w;
    logic              masked_w;

    dwn_timer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_re     (bus_re),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cnt        (cnt_w),
        .raw        (raw_w),
        .masked     (masked_w),
        .reload_lo  (reload_lo_w),
        .reload_hi  (reload_hi_w),
        .periodic   (periodic_w),
        .run        (run_w),
        .wide       (wide_w),
        .int_en     (int_en_w),
        .start      (start_w),
        .start_wide (start_wide_w),
        .clr        (clr_w)
    );

    dwn_timer_count #(.DATA_W(DATA_W)) count_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start_w),
        .start_wide (start_wide_w),
        .run        (run_w),
        .periodic   (periodic_w),
        .wide       (wide_w),
        .reload_lo  (reload_lo_w),
        .reload_hi  (reload_hi_w),
        .cnt        (cnt_w),
        .expire     (expire_w)
    );

    dwn_timer_irq irq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .expire (expire_w),
        .clr    (clr_w),
        .int_en (int_en_w),
        .raw    (raw_w),
        .masked (masked_w),
        .irq_o  (irq_o)
    );

endmodule

// File: rtl/dwn_timer_chk.sv
// Property checker for the timer, attached to the top by bind.
// Watches the counter, the status flag and the bus read port every clock.
module dwn_timer_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 5,
    localparam int unsigned CNT_W = 2 * DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              run,
    input logic              periodic,
    input logic              wide,
    input logic [CNT_W-1:0]  cnt,
    input logic [DATA_W-1:0] reload_lo,
    input logic              expire,
    input logic              raw,
    input logic              clr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_rdata
);

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> cnt[DATA_W-1:0] == $past(reload_lo)); // R2

    AST_DEC_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && wide && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R6

    AST_DEC_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && !wide && cnt[DATA_W-1:0] != '0)
        |=> cnt[DATA_W-1:0] == $past(cnt[DATA_W-1:0]) - 1'b1); // R3

    AST_FROZEN_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> $stable(cnt)); // R3

    AST_ONESHOT_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !periodic && !start && cnt == '0) |=> cnt == '0); // R5

    AST_EXPIRY_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> raw); // R8

    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (raw && !clr) |=> raw); // R9

    AST_RAW_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!raw && !expire) |=> !raw); // R8

    AST_HI_ZERO_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && bus_addr[4:0] == 5'h0C) |-> bus_rdata == '0); // R7

endmodule

bind dwn_timer_top dwn_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_w),
    .run       (run_w),
    .periodic  (periodic_w),
    .wide      (wide_w),
    .cnt       (cnt_w),
    .reload_lo (reload_lo_w),
    .expire    (expire_w),
    .raw       (raw_w),
    .clr       (clr_w),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata)
);

// File: tb/dwn_timer_tb_top.sv
`timescale 1ns/1ps
module dwn_timer_tb_top;

    localparam int unsigned DW = 32;
    localparam int unsigned AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic          bus_re = 1'b0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          irq_o;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    dwn_timer_top #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    // Reference model state, updated from the same pins on the same edge.
    logic [31:0] m_rlo, m_rhi, m_snap;
    logic        m_per, m_run, m_wide, m_ien, m_raw, m_done;
    logic [63:0] m_cnt;

    function automatic logic m_zero();
        return m_wide ? (m_cnt == 64'd0) : (m_cnt[31:0] == 32'd0);
    endfunction

    function automatic logic m_exp_pending();
        return m_run && m_zero() && (m_per || !m_done);
    endfunction

    function automatic logic [31:0] exp_rd(input int idx);
        case (idx)
            0: return m_rlo;
            1: return m_rhi;
            2: return m_cnt[31:0];
            3: return m_wide ? m_cnt[63:32] : 32'd0;
            4: return {15'd0, m_wide, 14'd0, m_run, m_per};
            5: return {29'd0, m_raw && m_ien, m_raw, m_ien};
            6: return m_cnt[31:0];
            default: return m_snap;
        endcase
    endfunction

    function automatic string tag_of(input int idx);
        case (idx)
            2: return "R3";
            3: return "R7";
            6, 7: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Clocked reference model built from the requirements.
    always @(posedge clk) begin
        logic st, cl, ex, aligned;
        int   wi;
        if (!rst_n) begin
            m_rlo <= 0; m_rhi <= 0; m_snap <= 0; m_per <= 0; m_run <= 0;
            m_wide <= 0; m_ien <= 0; m_raw <= 0; m_done <= 0; m_cnt <= 0;
        end else begin
            aligned = (bus_addr[1:0] == 2'b00);
            wi = int'(bus_addr[4:2]);
            st = bus_we && aligned && wi == 4 && bus_wdata[1] && !m_run;
            cl = bus_we && aligned && wi == 5 && bus_wdata[3];
            ex = m_run && !st && m_zero() && (m_per || !m_done);
            if (st) begin
                m_cnt  <= {(bus_wdata[16] ? m_rhi : 32'd0), m_rlo};
                m_done <= 1'b0;
            end else if (m_run) begin
                if (ex) begin
                    if (m_per) m_cnt <= {(m_wide ? m_rhi : 32'd0), m_rlo};
                    else       m_done <= 1'b1;
                end else if (!m_zero()) begin
                    if (m_wide) m_cnt <= m_cnt - 64'd1;
                    else        m_cnt <= {m_cnt[63:32], m_cnt[31:0] - 32'd1};
                end
            end
            if (ex)      m_raw <= 1'b1;
            else if (cl) m_raw <= 1'b0;
            if (bus_we && aligned) begin
                case (wi)
                    0: m_rlo <= bus_wdata;
                    1: m_rhi <= bus_wdata;
                    4: begin m_per <= bus_wdata[0]; m_run <= bus_wdata[1]; m_wide <= bus_wdata[16]; end
                    5: m_ien <= bus_wdata[0];
                    default: ;
                endcase
            end
            if (bus_re && aligned && wi == 6)
                m_snap <= m_wide ? m_cnt[63:32] : 32'd0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One write access; entered and left at a falling edge.
    task automatic bus_wr(input int idx, input logic [31:0] data);
        bus_addr = AW'(idx << 2); bus_wdata = data; bus_we = 1'b1; bus_re = 1'b0;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // One read access, compared against the model and the interrupt pin.
    task automatic bus_rd(input int idx, output logic [31:0] val);
        bus_addr = AW'(idx << 2); bus_re = 1'b1; bus_we = 1'b0;
        #1;
        val = bus_rdata;
        chk(tag_of(idx), bus_rdata, exp_rd(idx));
        chk("R8", {31'd0, irq_o}, {31'd0, m_raw && m_ien});
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        #1000000;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int guard;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 8; i++) begin
            bus_rd(i, v);
            chk("R1", v, 32'd0);
        end
        chk("R1", {31'd0, irq_o}, 32'd0);

        // R2/R3/R4: 32-bit periodic, reload 5
        bus_wr(0, 32'd5);
        bus_wr(4, 32'h3);
        for (int i = 0; i < 13; i++) begin
            bus_rd(2, v);
            chk(i < 6 ? "R2" : "R4", v, 32'd5 - 32'(i % 6));
        end
        bus_rd(5, v);
        chk("R8", {31'd0, v[1]}, 32'd1);
        chk("R8", {31'd0, irq_o}, 32'd0);
        bus_wr(5, 32'h1);
        bus_rd(5, v);
        chk("R8", {31'd0, v[2]}, 32'd1);

        // R3: stop freezes the count
        bus_wr(4, 32'h0);
        bus_rd(2, v);
        idle(4);
        bus_rd(2, v2);
        chk("R3", v2, v);

        // R11: read-only and misaligned writes ignored
        bus_wr(2, 32'h1234);
        bus_wr(6, 32'h55);
        bus_rd(2, v2);
        chk("R11", v2, v);
        bus_addr = 5'h01; bus_wdata = 32'hFF; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
        bus_rd(0, v2);
        chk("R11", v2, 32'd5);

        // R5: one-shot, reload 3
        bus_wr(5, 32'h9);
        bus_wr(0, 32'd3);
        bus_wr(4, 32'h2);
        idle(10);
        bus_rd(2, v);
        chk("R5", v, 32'd0);
        bus_rd(5, v);
        chk("R5", {31'd0, v[1]}, 32'd1);
        bus_wr(5, 32'h9);
        idle(10);
        bus_rd(5, v);
        chk("R5", {31'd0, v[1]}, 32'd0);
        bus_rd(2, v);
        chk("R5", v, 32'd0);

        // R6: 64-bit borrow, no expiry when only the low word is zero
        bus_wr(4, 32'h0);
        bus_wr(5, 32'h8);
        bus_wr(0, 32'd1);
        bus_wr(1, 32'd1);
        bus_wr(4, 32'h0001_0002);
        bus_rd(2, v);  chk("R6", v, 32'd1);
        bus_rd(2, v);  chk("R6", v, 32'd0);
        bus_rd(3, v);  chk("R6", v, 32'd0);
        bus_rd(2, v);  chk("R6", v, 32'hFFFF_FFFE);
        bus_rd(5, v);  chk("R6", v, 32'd0);

        // R10: snapshot pair with a nonzero high word
        bus_wr(4, 32'h0);
        bus_wr(0, 32'h10);
        bus_wr(1, 32'd3);
        bus_wr(4, 32'h0001_0002);
        bus_rd(6, v);
        chk("R10", v, 32'h10);
        idle(3);
        bus_rd(7, v);
        chk("R10", v, 32'd3);

        // R7: 32-bit mode hides a nonzero high reload word
        bus_wr(4, 32'h0);
        bus_wr(1, 32'hABCD);
        bus_wr(0, 32'd100);
        bus_wr(4, 32'h2);
        bus_rd(3, v);  chk("R7", v, 32'd0);
        bus_rd(6, v);
        bus_rd(7, v);  chk("R7", v, 32'd0);

        // R11: control and interrupt readback masks
        bus_wr(4, 32'h0);
        bus_wr(4, 32'hFFFF_FFFF);
        bus_rd(4, v);
        chk("R11", v, 32'h0001_0003);
        bus_wr(5, 32'hFFFF_FFF9);
        bus_rd(5, v);
        chk("R11", {28'd0, v[3], 3'd0}, 32'd0);

        // R9: expiry and clear on the same edge
        bus_wr(4, 32'h0);
        bus_wr(0, 32'd2);
        bus_wr(4, 32'h3);
        guard = 0;
        while (!m_exp_pending() && guard < 20) begin
            idle(1);
            guard++;
        end
        bus_wr(5, 32'h9);
        bus_rd(5, v);
        chk("R9", {31'd0, v[1]}, 32'd1);

        // Random traffic against the model
        for (int i = 0; i < 400; i++) begin
            int op, idx;
            logic [31:0] d;
            op  = int'($urandom_range(0, 9));
            idx = int'($urandom_range(0, 7));
            d   = $urandom();
            if (idx <= 1) d = d & 32'h1F;
            if (op < 4)      bus_rd(idx, v);
            else if (op < 7) bus_wr(idx, d);
            else             idle(1);
        end

        summary();
        $finish;
    end

endmodule